// File: doc/BRIEF.md
# Serial Port Event Flags and Interrupt Unit

This block keeps the status flags of a serial port's transmit and receive paths. It keeps the byte the CPU has queued for transmission and merges the enabled events into one interrupt request. A CPU reaches it through a small register bus with an address, read and write strobes and a data byte. The datapath behind it is a bit-level transmitter and receiver. That datapath reports single-cycle strobes for transmit finished, byte received, idle line, overrun, noise, framing error and parity error. It also reports when the transmit shifter can take a new byte.

Flags are never cleared by writing them. Software clears them with a two-step sequence: it reads the status register, then accesses the data register. A data read clears the receive-side flags that were visible at the status read. A data write clears the transmit-side flags and releases the queued byte to the shifter. A single interrupt line carries every enabled event and is gated by the CPU's global mask. A wait input turns a pending interrupt into a wake-up request. A halt input freezes the whole block.

Top module: `uart_evt_unit`

## Requirements
- R1: After reset the status register reads 0xC0, the control register reads 0x00, and irq, wake_req and tx_load are low.
- R2: The status byte has bit 7 = transmit holding empty, bit 6 = transmit complete, bit 5 = receive byte ready, bit 4 = idle line, bit 3 = overrun, bit 2 = noise, bit 1 = framing error, bit 0 = parity error. Each bit is set by its datapath strobe.
- R3: The transmit-empty flag clears only when a status read (address 0) is followed by a data write (address 1). A data write with no status read since the previous data access leaves the flag set and the shifter is not loaded.
- R4: While the transmit-empty flag is clear and tx_ready is high, tx_load is high in that cycle with tx_byte equal to the last byte written. From the next cycle the transmit-empty flag is set again.
- R5: A status read followed by a data read clears those of status bits 5..0 that were set at the time of the status read. A flag set between the two accesses stays set.
- R6: A data read returns the byte captured with the last rx_valid strobe.
- R7: The transmit-complete flag clears with the same sequence as R3. tx_done sets it only while no byte is queued; while a byte is queued, tx_done leaves it clear.
- R8: The control register (address 2) holds enables in bits 0..4: bit 0 receive (byte ready and overrun), bit 1 transmit empty, bit 2 transmit complete, bit 3 idle, bit 4 parity. irq is high when an enabled flag is set and cpu_imask is low.
- R9: The noise and framing flags never raise irq, whatever the enables.
- R10: While pwr_wait is high, wake_req follows irq; otherwise wake_req is low.
- R11: While pwr_halt is high, every register holds its value: bus accesses, datapath strobes and loads are ignored. tx_load and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register select: 0 status, 1 data, 2 control |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high |
| cpu_imask | input | 1 | Global interrupt mask, high blocks irq |
| pwr_wait | input | 1 | Wait mode active |
| pwr_halt | input | 1 | Halt mode active |
| tx_ready | input | 1 | Transmit shifter can accept a byte |
| tx_load | output | 1 | Transfer of tx_byte into the shifter this cycle |
| tx_byte | output | DATA_W | Queued transmit byte |
| tx_done | input | 1 | Strobe: shifter finished a frame |
| rx_valid | input | 1 | Strobe: byte received |
| rx_data | input | DATA_W | Received byte, valid with rx_valid |
| rx_idle | input | 1 | Strobe: idle line seen |
| rx_overrun | input | 1 | Strobe: receive overrun |
| rx_noise | input | 1 | Strobe: noise seen |
| rx_frame_err | input | 1 | Strobe: framing error |
| rx_parity_err | input | 1 | Strobe: parity error |
| irq | output | 1 | Combined interrupt request |
| wake_req | output | 1 | Wake-up request in wait mode |

## Verification
The assertions check on every cycle the properties that need no history of software accesses. A load always sets the transmit-empty flag on the next cycle. Halt freezes the status and blocks irq. The global mask blocks irq. The noise and framing flags alone never raise irq. A queued byte keeps transmit-complete clear across tx_done. Only the bench scenarios can show that the effect depends on the order of accesses. They cover a data write with no status read first, and a flag that arrives between the two steps and survives. They also show that a status read made during halt does not start a clear sequence.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;

    localparam int STAT_W = 8;
    localparam int RXF_W  = 6;
    localparam int SEL_STAT = 0;
    localparam int SEL_DATA = 1;
    localparam int SEL_CTRL = 2;

    // order is the software-visible bit layout, MSB first
    typedef struct packed {
        logic tdre;
        logic tc;
        logic rdrf;
        logic idle;
        logic ovr;
        logic noise;
        logic frame;
        logic parity;
    } stat_t;

    typedef struct packed {
        logic par_en;
        logic idle_en;
        logic txc_en;
        logic txe_en;
        logic rx_en;
    } ctrl_t;

    typedef struct packed {
        logic tdre;
        logic tc;
        logic rdrf;
        logic idle;
        logic ovr;
        logic parity;
    } irq_flags_t;

    typedef struct packed {
        logic stat_rd;
        logic data_rd;
        logic data_wr;
        logic ctrl_wr;
    } bus_op_t;

    typedef enum logic [1:0] {
        ARM_IDLE = 2'b00,
        ARM_SET  = 2'b01
    } arm_state_e;

    localparam stat_t STAT_RESET = '{tdre: 1'b1, tc: 1'b1, default: 1'b0};

    function automatic logic [5:0] irq_sources(irq_flags_t f, ctrl_t c);
        return {f.tdre & c.txe_en, f.tc & c.txc_en, f.rdrf & c.rx_en,
                f.ovr & c.rx_en, f.idle & c.idle_en, f.parity & c.par_en};
    endfunction

endpackage

// File: rtl/uart_evt_regs.sv
module uart_evt_regs
    import uart_evt_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output bus_op_t           op,
    output logic              clr_rx,
    output logic              clr_tx,
    output ctrl_t             ctrl
);

    localparam int CTRL_W = $bits(ctrl_t);

    arm_state_e arm_q;
    logic       unused_hi;

    always_comb begin
        op.stat_rd = rd & ~halt & (addr == ADDR_W'(SEL_STAT));
        op.data_rd = rd & ~halt & (addr == ADDR_W'(SEL_DATA));
        op.data_wr = wr & ~halt & (addr == ADDR_W'(SEL_DATA));
        op.ctrl_wr = wr & ~halt & (addr == ADDR_W'(SEL_CTRL));
    end

    assign clr_rx    = op.data_rd & (arm_q == ARM_SET);
    assign clr_tx    = op.data_wr & (arm_q == ARM_SET);
    assign unused_hi = ^wdata[DATA_W-1:CTRL_W];

    // any data access consumes the arm; only the matching direction acts
    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= ARM_IDLE;
        end else if (op.stat_rd) begin
            arm_q <= ARM_SET;
        end else if (op.data_rd || op.data_wr) begin
            arm_q <= ARM_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (op.ctrl_wr) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]) | ctrl_t'(unused_hi & 1'b0);
        end
    end

endmodule

// File: rtl/uart_evt_flags.sv
module uart_evt_flags
    import uart_evt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic              stat_rd,
    input  logic              data_wr,
    input  logic              clr_rx,
    input  logic              clr_tx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_ready,
    input  logic              tx_done,
    input  logic              ev_rx,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              ev_idle,
    input  logic              ev_ovr,
    input  logic              ev_noise,
    input  logic              ev_frame,
    input  logic              ev_parity,
    output stat_t             stat,
    output logic [DATA_W-1:0] rx_hold,
    output logic [DATA_W-1:0] tx_hold,
    output logic              tx_load
);

    logic             tdre_q, tc_q;
    logic [RXF_W-1:0] rxf_q, snap_q, rx_set;

    assign rx_set  = {ev_rx, ev_idle, ev_ovr, ev_noise, ev_frame, ev_parity} & {RXF_W{~halt}};
    assign tx_load = ~tdre_q & tx_ready & ~halt;

    // receive-side flags: one cell per bit, a new event wins over the clear
    for (genvar i = 0; i < RXF_W; i++) begin : g_rxf
        always_ff @(posedge clk) begin
            if (rst) begin
                rxf_q[i] <= 1'b0;
            end else if (rx_set[i]) begin
                rxf_q[i] <= 1'b1;
            end else if (clr_rx && snap_q[i]) begin
                rxf_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                snap_q[i] <= 1'b0;
            end else if (stat_rd) begin
                snap_q[i] <= rxf_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tdre_q <= STAT_RESET.tdre;
            tc_q   <= STAT_RESET.tc;
        end else if (!halt) begin
            if (tx_load) begin
                tdre_q <= 1'b1;
            end else if (clr_tx) begin
                tdre_q <= 1'b0;
            end
            if (clr_tx) begin
                tc_q <= 1'b0;
            end else if (tx_done && tdre_q) begin
                tc_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_hold <= '0;
            tx_hold <= '0;
        end else begin
            if (ev_rx && !halt) begin
                rx_hold <= rx_data;
            end
            if (data_wr) begin
                tx_hold <= wdata;
            end
        end
    end

    always_comb begin
        stat        = '0;
        stat.tdre   = tdre_q;
        stat.tc     = tc_q;
        stat.rdrf   = rxf_q[5];
        stat.idle   = rxf_q[4];
        stat.ovr    = rxf_q[3];
        stat.noise  = rxf_q[2];
        stat.frame  = rxf_q[1];
        stat.parity = rxf_q[0];
    end

endmodule

// File: rtl/uart_evt_irq.sv
module uart_evt_irq
    import uart_evt_pkg::*;
(
    input  irq_flags_t flags,
    input  ctrl_t      ctrl,
    input  logic       imask,
    input  logic       halt,
    input  logic       wait_mode,
    output logic       irq,
    output logic       wake
);

    logic [5:0] src;

    assign src  = irq_sources(flags, ctrl);
    assign irq  = (|src) & ~imask & ~halt;
    assign wake = irq & wait_mode;

endmodule

// File: rtl/uart_evt_unit.sv
module uart_evt_unit
    import uart_evt_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cpu_imask,
    input  logic              pwr_wait,
    input  logic              pwr_halt,
    input  logic              tx_ready,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_idle,
    input  logic              rx_overrun,
    input  logic              rx_noise,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    output logic              irq,
    output logic              wake_req
);

    bus_op_t           op;
    logic              clr_rx, clr_tx;
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    irq_flags_t        iflags;
    logic [DATA_W-1:0] rx_hold;

    uart_evt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst(rst), .halt(pwr_halt), .addr(bus_addr),
        .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
        .op(op), .clr_rx(clr_rx), .clr_tx(clr_tx), .ctrl(ctrl_q)
    );

    uart_evt_flags #(.DATA_W(DATA_W)) flags_i (
        .clk(clk), .rst(rst), .halt(pwr_halt),
        .stat_rd(op.stat_rd), .data_wr(op.data_wr),
        .clr_rx(clr_rx), .clr_tx(clr_tx), .wdata(bus_wdata),
        .tx_ready(tx_ready), .tx_done(tx_done),
        .ev_rx(rx_valid), .rx_data(rx_data), .ev_idle(rx_idle),
        .ev_ovr(rx_overrun), .ev_noise(rx_noise), .ev_frame(rx_frame_err),
        .ev_parity(rx_parity_err),
        .stat(stat_q), .rx_hold(rx_hold), .tx_hold(tx_byte), .tx_load(tx_load)
    );

    always_comb begin
        iflags.tdre   = stat_q.tdre;
        iflags.tc     = stat_q.tc;
        iflags.rdrf   = stat_q.rdrf;
        iflags.idle   = stat_q.idle;
        iflags.ovr    = stat_q.ovr;
        iflags.parity = stat_q.parity;
    end

    uart_evt_irq irq_i (
        .flags(iflags), .ctrl(ctrl_q), .imask(cpu_imask), .halt(pwr_halt),
        .wait_mode(pwr_wait), .irq(irq), .wake(wake_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(SEL_STAT)) begin
                bus_rdata = DATA_W'(stat_q);
            end else if (bus_addr == ADDR_W'(SEL_DATA)) begin
                bus_rdata = rx_hold;
            end else if (bus_addr == ADDR_W'(SEL_CTRL)) begin
                bus_rdata = DATA_W'(ctrl_q);
            end
        end
    end

endmodule

// File: rtl/uart_evt_chk.sv
module uart_evt_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] stat_bits,
    input logic       tx_load,
    input logic       tx_done,
    input logic       cpu_imask,
    input logic       pwr_halt,
    input logic       irq
);

    AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> stat_bits[7]); // R4

    AST_TC_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !stat_bits[7] && !stat_bits[6]) |=> !stat_bits[6]); // R7

    AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (rst)
        cpu_imask |-> !irq); // R8

    AST_NFFE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(stat_bits & 8'hF9))); // R9

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        pwr_halt |=> $stable(stat_bits)); // R11

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        pwr_halt |-> (!irq && !tx_load)); // R11

endmodule

bind uart_evt_unit uart_evt_chk chk_i (
    .clk(clk), .rst(rst), .stat_bits(stat_q), .tx_load(tx_load),
    .tx_done(tx_done), .cpu_imask(cpu_imask), .pwr_halt(pwr_halt), .irq(irq)
);

// File: tb/uart_evt_unit_tb_top.sv
module uart_evt_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cpu_imask = 1'b0, pwr_wait = 1'b0, pwr_halt = 1'b0;
    logic       tx_ready = 1'b0, tx_load, tx_done = 1'b0;
    logic [7:0] tx_byte;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_idle = 1'b0, rx_overrun = 1'b0, rx_noise = 1'b0;
    logic       rx_frame_err = 1'b0, rx_parity_err = 1'b0;
    logic       irq, wake_req;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    uart_evt_unit dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_imask(cpu_imask),
        .pwr_wait(pwr_wait), .pwr_halt(pwr_halt), .tx_ready(tx_ready),
        .tx_load(tx_load), .tx_byte(tx_byte), .tx_done(tx_done),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_idle(rx_idle),
        .rx_overrun(rx_overrun), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .irq(irq), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #5 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    // pulse bitmap: 6 done,5 rx,4 idle,3 overrun,2 noise,1 frame,0 parity
    task automatic pulse(input logic [6:0] m, input logic [7:0] d);
        @(negedge clk);
        {tx_done, rx_valid, rx_idle, rx_overrun, rx_noise, rx_frame_err, rx_parity_err} = m;
        rx_data = d;
        @(posedge clk); #1
        {tx_done, rx_valid, rx_idle, rx_overrun, rx_noise, rx_frame_err, rx_parity_err} = '0;
    endtask

    task automatic expect_stat(input string req, input logic [7:0] exp);
        logic [7:0] d;
        bus_read(2'd0, d);
        check(req, d, exp);
    endtask

    task automatic sample_pins(output logic [7:0] v);
        @(negedge clk); #5 v = {4'b0, tx_load, wake_req, irq, 1'b0};
    endtask

    task automatic load_byte(input string req, input logic [7:0] exp_byte);
        @(negedge clk); tx_ready = 1'b1;
        #5 check({req, " load"}, {7'b0, tx_load}, 8'h01);
        check({req, " byte"}, tx_byte, exp_byte);
        @(posedge clk); #1 tx_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic [7:0] p;
        sample_pins(p);
        check("R1 pins", p, 8'h00);
        bus_read(2'd2, d);
        check("R1 ctrl", d, 8'h00);
        expect_stat("R1 status", 8'hC0);
    endtask

    task automatic t_write_no_seq();
        logic [7:0] d;
        bus_read(2'd1, d);          // consume any arm
        bus_write(2'd1, 8'h5A);
        @(negedge clk); tx_ready = 1'b1;
        #5 check("R3 no load without sequence", {7'b0, tx_load}, 8'h00);
        @(posedge clk); #1 tx_ready = 1'b0;
        expect_stat("R3 empty stays set", 8'hC0);
    endtask

    task automatic t_tx_seq();
        logic [7:0] d;
        bus_read(2'd0, d);
        bus_write(2'd1, 8'hA5);
        expect_stat("R3 R7 sequence clears empty and complete", 8'h00);
        load_byte("R4", 8'hA5);
        expect_stat("R4 empty after load", 8'h80);
        pulse(7'b100_0000, 8'h00);
        expect_stat("R7 complete set after done", 8'hC0);
    endtask

    task automatic t_tc_pending();
        logic [7:0] d;
        bus_read(2'd0, d);
        bus_write(2'd1, 8'h11);
        pulse(7'b100_0000, 8'h00);
        expect_stat("R7 done while queued", 8'h00);
        load_byte("R4 second", 8'h11);
        pulse(7'b100_0000, 8'h00);
        expect_stat("R7 done after load", 8'hC0);
    endtask

    task automatic t_rx();
        logic [7:0] d;
        pulse(7'b010_0001, 8'h3C);
        expect_stat("R2 ready and parity bits", 8'hE1);
        pulse(7'b000_0010, 8'h00);
        bus_read(2'd1, d);
        check("R6 data read", d, 8'h3C);
        expect_stat("R5 late framing flag survives", 8'hC2);
        bus_read(2'd1, d);
        expect_stat("R5 cleared", 8'hC0);
        pulse(7'b001_1100, 8'h00);
        expect_stat("R2 idle overrun noise bits", 8'hDC);
        bus_read(2'd1, d);
        expect_stat("R5 cleared again", 8'hC0);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        logic [7:0] p;
        bus_write(2'd2, 8'h01);
        bus_read(2'd2, d);
        check("R8 ctrl readback", d, 8'h01);
        sample_pins(p);
        check("R8 no source", p, 8'h00);
        pulse(7'b010_0000, 8'h42);
        sample_pins(p);
        check("R8 receive irq", p, 8'h02);
        cpu_imask = 1'b1;
        sample_pins(p);
        check("R8 masked", p, 8'h00);
        cpu_imask = 1'b0;
        pwr_wait = 1'b1;
        sample_pins(p);
        check("R10 wake in wait", p, 8'h06);
        pwr_wait = 1'b0;
        sample_pins(p);
        check("R10 no wake outside wait", p, 8'h02);
        bus_read(2'd0, d);
        bus_read(2'd1, d);
        sample_pins(p);
        check("R8 irq drops after clear", p, 8'h00);
        bus_write(2'd2, 8'h02);
        sample_pins(p);
        check("R8 empty enable", p, 8'h02);
        bus_write(2'd2, 8'h04);
        sample_pins(p);
        check("R8 complete enable", p, 8'h02);
        bus_write(2'd2, 8'h00);
        bus_read(2'd0, d);
        bus_write(2'd1, 8'h99);
        bus_write(2'd2, 8'h1F);
        sample_pins(p);
        check("R8 all enables nothing set", p, 8'h00);
        pulse(7'b000_0110, 8'h00);
        expect_stat("R2 noise framing bits", 8'h06);
        sample_pins(p);
        check("R9 noise framing silent", p, 8'h00);
        pulse(7'b001_0000, 8'h00);
        sample_pins(p);
        check("R8 idle enable", p, 8'h02);
        bus_read(2'd0, d);
        bus_read(2'd1, d);
        bus_write(2'd2, 8'h00);
        load_byte("R4 third", 8'h99);
        pulse(7'b100_0000, 8'h00);
        expect_stat("R7 back to idle", 8'hC0);
    endtask

    task automatic t_halt();
        logic [7:0] d;
        logic [7:0] p;
        pulse(7'b010_0000, 8'h21);
        bus_write(2'd2, 8'h01);
        bus_read(2'd0, d);
        check("R2 ready before halt", d, 8'hE0);
        bus_write(2'd1, 8'h77);
        pwr_halt = 1'b1;
        @(negedge clk); tx_ready = 1'b1;
        #5 check("R11 pins in halt", {4'b0, tx_load, wake_req, irq, 1'b0}, 8'h00);
        @(posedge clk); #1 tx_ready = 1'b0;
        pulse(7'b000_0001, 8'h00);
        bus_write(2'd2, 8'h00);
        bus_read(2'd0, d);
        pwr_halt = 1'b0;
        bus_read(2'd2, d);
        check("R11 ctrl write ignored", d, 8'h01);
        sample_pins(p);
        check("R11 irq back after halt", p, 8'h02);
        bus_read(2'd1, d);
        check("R6 byte before halt", d, 8'h21);
        expect_stat("R11 no parity, halted read did not arm", 8'h20);
        bus_read(2'd1, d);
        expect_stat("R5 cleared after halt", 8'h00);
        load_byte("R4 after halt", 8'h77);
        pulse(7'b100_0000, 8'h00);
        bus_write(2'd2, 8'h00);
        expect_stat("R7 final", 8'hC0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_write_no_seq();
        t_tx_seq();
        t_tc_pending();
        t_rx();
        t_irq();
        t_halt();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule